// File: doc/BRIEF.md
# Rotating Register Rename Unit

This block turns logical register numbers into physical register numbers for software-pipelined loops. It covers three register classes. General registers have 128 entries and rotate over a programmable span that starts at register 32. Floating-point registers have 128 entries and rotate over the fixed span 32..127. Predicates have 64 entries and rotate over the fixed span 16..63. Each class keeps a rotation base. A logical number inside the rotating span is offset by that base, and the result wraps at the span size. Numbers outside the span pass through unchanged.

A loop-branch pulse advances all three bases by one, so a name that pointed at physical register 32 on one iteration points at 33 on the next. The same pulse tests and decrements a loop counter that software loads through a write strobe. The block reports, one cycle later, whether the branch was taken. The three lookups are purely combinational and carry no stream handshake, because each lookup is a single-cycle index translation. All other pins are plain control strobes with no back-pressure.

Top module: `rot_rename_unit`

## Requirements
- R1: After reset all three bases are zero, the general-register span is zero, the loop counter is zero, and every lookup returns its own input.
- R2: A logical index below its class's rotating start is returned unchanged: below 32 for general and floating-point registers, below 16 for predicates.
- R3: A floating-point index L in 32..127 maps to 32 + ((L - 32 + k) mod 96), where k is the number of loop branches since reset.
- R4: A predicate index L in 16..63 maps to 16 + ((L - 16 + k) mod 48).
- R5: With a general span S, an index L with 32 <= L < 32+S maps to 32 + ((L - 32 + k) mod S), where k counts branches since the last span write. An index at or above 32+S is returned unchanged.
- R6: A span write stores the value rounded down to a multiple of 8, limited to 96. For example, 21 becomes 16 and 200 becomes 96.
- R7: A span write clears the general-register base to zero. This holds even when a loop branch arrives in the same cycle.
- R8: On a loop branch, the branch-taken output in the next cycle is 1 when the counter was nonzero, and the counter then decrements. When the counter was zero, the output is 0, the counter stays at zero, and the rotation still happens.
- R9: The base wraps at the span size: after exactly 96 branches, every floating-point lookup is the identity again.
- R10: With a general span of zero, loop branches leave the general-register mapping unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gr_size_wr | input | 1 | Strobe that loads the general rotating span |
| gr_size_val | input | 8 | Requested general span, rounded down and limited |
| lc_wr | input | 1 | Strobe that loads the loop counter |
| lc_val | input | 16 | Loop counter load value |
| loop_br | input | 1 | Counted loop branch: rotate and test/decrement the counter |
| gr_log_idx | input | 7 | Logical general register number |
| gr_phys_idx | output | 7 | Physical general register number |
| fr_log_idx | input | 7 | Logical floating-point register number |
| fr_phys_idx | output | 7 | Physical floating-point register number |
| pr_log_idx | input | 6 | Logical predicate number |
| pr_phys_idx | output | 6 | Physical predicate number |
| br_done | output | 1 | Pulses one cycle after a loop branch |
| br_taken | output | 1 | Taken result of that branch, valid with br_done |

## Verification
The assertions assume three things about the inputs. The loop counter is never loaded in the same cycle as a loop branch. Logical indices stay within their class width. Strobes are single-cycle pulses. The counter-decrement property also relies on no counter load sharing the branch cycle.

The directed stimulus applies every strobe for exactly one cycle, away from the clock edge. It keeps counter loads and branches in separate cycles. The only deliberate collision is a span write issued together with a branch, which the design defines and R7 covers.

// File: rtl/rrn_pkg.sv
package rrn_pkg;
  localparam int GR_COUNT  = 128;
  localparam int FR_COUNT  = 128;
  localparam int PR_COUNT  = 64;
  localparam int GR_START  = 32;
  localparam int FR_START  = 32;
  localparam int PR_START  = 16;
  localparam int SPAN_STEP = 8;
  localparam int LC_W      = 16;
  localparam int SIZE_W    = 8;
endpackage

// File: rtl/rrn_size_reg.sv
module rrn_size_reg #(
  parameter int SIZE_W   = 8,
  parameter int SPAN_W   = 7,
  parameter int MAX_SPAN = 96,
  parameter int STEP     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [SIZE_W-1:0] val,
  output logic [SPAN_W-1:0] span
);
  localparam int LOW_BITS = $clog2(STEP);

  logic [SIZE_W-1:0] limited;
  logic [SIZE_W-1:0] rounded;

  always_comb begin
    if (val > SIZE_W'(MAX_SPAN)) limited = SIZE_W'(MAX_SPAN);
    else                         limited = val;
    rounded = limited;
    rounded[LOW_BITS-1:0] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  span <= '0;
    else if (wr) span <= rounded[SPAN_W-1:0];
  end
endmodule

// File: rtl/rrn_region.sv
module rrn_region #(
  parameter int IDX_W = 7,
  parameter int START = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] span,
  input  logic             rot,
  input  logic             clr,
  input  logic [IDX_W-1:0] log_idx,
  output logic [IDX_W-1:0] phys_idx,
  output logic [IDX_W-1:0] base_o
);
  logic [IDX_W-1:0] base_q;
  logic [IDX_W-1:0] off;
  logic [IDX_W:0]   sum;
  logic [IDX_W:0]   wrapped;
  logic [IDX_W-1:0] base_inc;

  assign base_inc = base_q + 1'b1;
  assign base_o   = base_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    base_q <= '0;
    else if (clr)                  base_q <= '0;
    else if (rot && span != '0)    base_q <= (base_inc >= span) ? '0 : base_inc;
  end

  always_comb begin
    off      = log_idx - IDX_W'(START);
    sum      = {1'b0, off} + {1'b0, base_q};
    wrapped  = (sum >= {1'b0, span}) ? sum - {1'b0, span} : sum;
    phys_idx = log_idx;
    if (log_idx >= IDX_W'(START) && off < span)
      phys_idx = IDX_W'(START) + wrapped[IDX_W-1:0];
  end
endmodule

// File: rtl/rrn_loop_ctrl.sv
module rrn_loop_ctrl #(
  parameter int LC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lc_wr,
  input  logic [LC_W-1:0] lc_val,
  input  logic            loop_br,
  output logic [LC_W-1:0] lc_q,
  output logic            done,
  output logic            taken
);
  logic nz;
  assign nz = (lc_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lc_q  <= '0;
      done  <= 1'b0;
      taken <= 1'b0;
    end else begin
      done  <= loop_br;
      taken <= loop_br && nz;
      if (lc_wr)              lc_q <= lc_val;
      else if (loop_br && nz) lc_q <= lc_q - 1'b1;
    end
  end
endmodule

// File: rtl/rot_rename_unit.sv
module rot_rename_unit
  import rrn_pkg::*;
#(
  parameter int GR_W = $clog2(GR_COUNT),
  parameter int FR_W = $clog2(FR_COUNT),
  parameter int PR_W = $clog2(PR_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gr_size_wr,
  input  logic [SIZE_W-1:0] gr_size_val,
  input  logic              lc_wr,
  input  logic [LC_W-1:0]   lc_val,
  input  logic              loop_br,
  input  logic [GR_W-1:0]   gr_log_idx,
  output logic [GR_W-1:0]   gr_phys_idx,
  input  logic [FR_W-1:0]   fr_log_idx,
  output logic [FR_W-1:0]   fr_phys_idx,
  input  logic [PR_W-1:0]   pr_log_idx,
  output logic [PR_W-1:0]   pr_phys_idx,
  output logic              br_done,
  output logic              br_taken
);
  localparam int GR_MAX = GR_COUNT - GR_START;
  localparam int FR_MAX = FR_COUNT - FR_START;
  localparam int PR_MAX = PR_COUNT - PR_START;

  logic [GR_W-1:0] gr_span;
  logic [GR_W-1:0] gr_base;
  logic [FR_W-1:0] fr_base;
  logic [PR_W-1:0] pr_base;
  logic [LC_W-1:0] lc_q;

  rrn_size_reg #(.SIZE_W(SIZE_W), .SPAN_W(GR_W), .MAX_SPAN(GR_MAX), .STEP(SPAN_STEP)) u_size (
    .clk(clk), .rst_n(rst_n), .wr(gr_size_wr), .val(gr_size_val), .span(gr_span));

  rrn_region #(.IDX_W(GR_W), .START(GR_START)) u_gr (
    .clk(clk), .rst_n(rst_n), .span(gr_span), .rot(loop_br), .clr(gr_size_wr),
    .log_idx(gr_log_idx), .phys_idx(gr_phys_idx), .base_o(gr_base));

  rrn_region #(.IDX_W(FR_W), .START(FR_START)) u_fr (
    .clk(clk), .rst_n(rst_n), .span(FR_W'(FR_MAX)), .rot(loop_br), .clr(1'b0),
    .log_idx(fr_log_idx), .phys_idx(fr_phys_idx), .base_o(fr_base));

  rrn_region #(.IDX_W(PR_W), .START(PR_START)) u_pr (
    .clk(clk), .rst_n(rst_n), .span(PR_W'(PR_MAX)), .rot(loop_br), .clr(1'b0),
    .log_idx(pr_log_idx), .phys_idx(pr_phys_idx), .base_o(pr_base));

  rrn_loop_ctrl #(.LC_W(LC_W)) u_loop (
    .clk(clk), .rst_n(rst_n), .lc_wr(lc_wr), .lc_val(lc_val), .loop_br(loop_br),
    .lc_q(lc_q), .done(br_done), .taken(br_taken));
endmodule

// File: rtl/rrn_checker.sv
module rrn_checker
  import rrn_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        gr_size_wr,
  input logic        lc_wr,
  input logic        loop_br,
  input logic [6:0]  gr_log_idx,
  input logic [6:0]  gr_phys_idx,
  input logic [6:0]  fr_log_idx,
  input logic [6:0]  fr_phys_idx,
  input logic [5:0]  pr_log_idx,
  input logic [5:0]  pr_phys_idx,
  input logic        br_done,
  input logic        br_taken,
  input logic [15:0] lc_q,
  input logic [6:0]  gr_span,
  input logic [6:0]  gr_base
);
  assert_below_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gr_log_idx < 7'd32) |-> (gr_phys_idx == gr_log_idx));
  assert_pr_below_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_log_idx < 6'd16) |-> (pr_phys_idx == pr_log_idx));
  assert_fr_in_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_log_idx >= 7'd32) |-> (fr_phys_idx >= 7'd32));
  assert_pr_in_region_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_log_idx >= 6'd16) |-> (pr_phys_idx >= 6'd16));
  assert_span_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gr_span[2:0] == 3'd0) && (gr_span <= 7'd96));
  assert_size_clears_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gr_size_wr |=> (gr_base == 7'd0));
  assert_done_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    loop_br |=> br_done);
  assert_taken_needs_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_br && !lc_wr && lc_q == 16'd0) |=> (!br_taken && lc_q == 16'd0));
  assert_decrement_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_br && !lc_wr && lc_q != 16'd0) |=> (br_taken && lc_q == $past(lc_q) - 16'd1));
  assert_gr_base_in_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gr_span != 7'd0) |-> (gr_base < gr_span));
endmodule

bind rot_rename_unit rrn_checker chk_i (
  .clk(clk), .rst_n(rst_n), .gr_size_wr(gr_size_wr), .lc_wr(lc_wr), .loop_br(loop_br),
  .gr_log_idx(gr_log_idx), .gr_phys_idx(gr_phys_idx), .fr_log_idx(fr_log_idx),
  .fr_phys_idx(fr_phys_idx), .pr_log_idx(pr_log_idx), .pr_phys_idx(pr_phys_idx),
  .br_done(br_done), .br_taken(br_taken), .lc_q(lc_q), .gr_span(gr_span), .gr_base(gr_base));

// File: tb/rot_rename_unit_tb_top.sv
`timescale 1ns/1ps
module rot_rename_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gr_size_wr = 1'b0;
  logic [7:0]  gr_size_val = '0;
  logic        lc_wr = 1'b0;
  logic [15:0] lc_val = '0;
  logic        loop_br = 1'b0;
  logic [6:0]  gr_log_idx = '0;
  logic [6:0]  gr_phys_idx;
  logic [6:0]  fr_log_idx = '0;
  logic [6:0]  fr_phys_idx;
  logic [5:0]  pr_log_idx = '0;
  logic [5:0]  pr_phys_idx;
  logic        br_done;
  logic        br_taken;

  int n_run = 0;
  int n_fail = 0;
  int k_fr = 0;
  int k_pr = 0;
  int k_gr = 0;
  int gr_sz = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rot_rename_unit dut_i (
    .clk(clk), .rst_n(rst_n), .gr_size_wr(gr_size_wr), .gr_size_val(gr_size_val),
    .lc_wr(lc_wr), .lc_val(lc_val), .loop_br(loop_br),
    .gr_log_idx(gr_log_idx), .gr_phys_idx(gr_phys_idx),
    .fr_log_idx(fr_log_idx), .fr_phys_idx(fr_phys_idx),
    .pr_log_idx(pr_log_idx), .pr_phys_idx(pr_phys_idx),
    .br_done(br_done), .br_taken(br_taken));

  function automatic int emap(int l, int start, int span, int k);
    if (l < start || l >= start + span || span == 0) return l;
    return start + ((l - start + k) % span);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic look_fr(int l, string req);
    fr_log_idx = 7'(l); #1;
    check(int'(fr_phys_idx) == emap(l, 32, 96, k_fr), req, fr_phys_idx, emap(l, 32, 96, k_fr));
  endtask
  task automatic look_pr(int l, string req);
    pr_log_idx = 6'(l); #1;
    check(int'(pr_phys_idx) == emap(l, 16, 48, k_pr), req, pr_phys_idx, emap(l, 16, 48, k_pr));
  endtask
  task automatic look_gr(int l, string req);
    gr_log_idx = 7'(l); #1;
    check(int'(gr_phys_idx) == emap(l, 32, gr_sz, k_gr), req, gr_phys_idx, emap(l, 32, gr_sz, k_gr));
  endtask

  task automatic branch(output bit tk, output bit dn);
    @(negedge clk) loop_br = 1'b1;
    @(negedge clk) loop_br = 1'b0;
    tk = br_taken; dn = br_done;
    k_fr++; k_pr++; k_gr++;
  endtask

  task automatic rot(int n);
    bit tk, dn;
    for (int i = 0; i < n; i++) branch(tk, dn);
  endtask

  task automatic set_size(int v, int eff);
    @(negedge clk) begin gr_size_wr = 1'b1; gr_size_val = 8'(v); end
    @(negedge clk) gr_size_wr = 1'b0;
    gr_sz = eff; k_gr = 0;
  endtask

  task automatic load_lc(int v);
    @(negedge clk) begin lc_wr = 1'b1; lc_val = 16'(v); end
    @(negedge clk) lc_wr = 1'b0;
  endtask

  task automatic t_reset;
    look_gr(40, "R1"); look_fr(100, "R1"); look_pr(20, "R1");
    check(br_done == 1'b0 && br_taken == 1'b0, "R1", {br_done, br_taken}, 0);
  endtask

  task automatic t_zero_span;
    rot(3);
    look_gr(32, "R10"); look_gr(90, "R10");
  endtask

  task automatic t_below_start;
    look_gr(5, "R2"); look_fr(31, "R2"); look_pr(15, "R2"); look_pr(0, "R2");
  endtask

  task automatic t_fr_rotate;
    rot(2);
    look_fr(32, "R3"); look_fr(127, "R3"); look_fr(80, "R3");
  endtask

  task automatic t_pr_rotate;
    look_pr(16, "R4"); look_pr(63, "R4"); look_pr(40, "R4");
  endtask

  task automatic t_clamp;
    set_size(21, 16);
    rot(1);
    look_gr(47, "R6"); look_gr(48, "R6"); look_gr(32, "R6");
    set_size(200, 96);
    rot(1);
    look_gr(127, "R6"); look_gr(33, "R6");
  endtask

  task automatic t_gr_prog;
    set_size(16, 16);
    rot(5);
    look_gr(32, "R5"); look_gr(45, "R5"); look_gr(47, "R5"); look_gr(48, "R5");
    rot(12);
    look_gr(32, "R5"); look_gr(47, "R5");
  endtask

  task automatic t_size_clears;
    rot(3);
    @(negedge clk) begin gr_size_wr = 1'b1; gr_size_val = 8'd24; loop_br = 1'b1; end
    @(negedge clk) begin gr_size_wr = 1'b0; loop_br = 1'b0; end
    k_fr++; k_pr++; gr_sz = 24; k_gr = 0;
    look_gr(32, "R7"); look_gr(55, "R7"); look_gr(56, "R7");
  endtask

  task automatic t_loop_count;
    bit tk, dn;
    load_lc(3);
    for (int i = 0; i < 3; i++) begin
      branch(tk, dn);
      check(dn && tk, "R8", tk, 1);
    end
    branch(tk, dn);
    check(dn && !tk, "R8", tk, 0);
    branch(tk, dn);
    check(!tk, "R8", tk, 0);
    look_fr(32, "R8");
    look_pr(16, "R8");
  endtask

  task automatic t_wrap;
    rot(96 - (k_fr % 96));
    for (int l = 32; l < 128; l += 19) begin
      fr_log_idx = 7'(l); #1;
      check(int'(fr_phys_idx) == l, "R9", fr_phys_idx, l);
    end
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_below_start;
    t_zero_span;
    t_fr_rotate;
    t_pr_rotate;
    t_clamp;
    t_gr_prog;
    t_size_clears;
    t_loop_count;
    t_below_start;
    t_wrap;
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule